// File: doc/BRIEF.md
# Display Power and Initialization Sequencer

This block brings a monochrome 128x64 dot-matrix display module up, puts it to sleep, wakes it and shuts it down in the order the panel needs. It owns three sideband lines: a logic-power enable, the module's active-low reset, and an enable for the panel high-voltage supply. Every configuration byte goes out through a generic byte-write port: a byte, a flag marking display data against command, and a valid/ready pair. A parallel or serial writer behind that port turns each accepted byte into bus cycles.

A start request samples a mode input. In one mode the panel voltage comes from an external supply that this block switches. In the other the module's internal charge pump makes it. The mode chooses the charge-pump setting written during setup, and it chooses whether the sleep, wake and power-down steps switch the external supply or rewrite the pump setting. After setup the block clears all of display memory. It then waits a fixed stabilization time, derived from a millisecond tick counter, before it turns the display on.

Top module: `dpy_power_seq`

## Requirements
- R1: During and after reset, logic_pwr_o, panel_rst_n_o, hv_en_o, busy_o and wr_valid_o are all low. While logic_pwr_o is low, panel_rst_n_o stays low.
- R2: A start_i seen while idle and powered off does the following in order. It raises logic_pwr_o. It drives panel_rst_n_o high for RST_CYC cycles, then low for RST_CYC cycles, then high again. The first byte is offered POST_CYC cycles after that last rise. No byte is ever offered while panel_rst_n_o or logic_pwr_o is low.
- R3: Power-up sends these command bytes (data flag 0) in this order: AE, 00, 10, 40, B0, 81, CF, A1, A6, A8, 3F, C8, D3, 00, D5, 80, D9, F1, DA, 12, DB, 30, 8D, then the pump argument. The last byte of the sequence is AF.
- R4: The pump argument is 10 when ext_supply_i was high at the accepted start, and 14 when it was low. The mode is sampled only at that start, so later changes to ext_supply_i have no effect until the next start.
- R5: The clear pass follows the setup list. It covers PAGES pages. Each page begins with the commands B0+page, 00 and 10, followed by COLS zero bytes with the data flag set to 1.
- R6: In external mode, hv_en_o rises in the cycle after the last clear byte is accepted. AF is offered exactly TICK_CYC*WAIT_MS cycles after that rise.
- R7: In external mode, sleep sends AE and then drops hv_en_o. Wake raises hv_en_o, waits TICK_CYC*WAIT_MS cycles, then sends AF.
- R8: Power-down from the on state sends AE, then the supply-off step (external: hv_en_o falls; internal: 8D, 10). It then holds logic_pwr_o high for TICK_CYC*WAIT_MS cycles before dropping it. hv_en_o is never high while logic_pwr_o is low.
- R9: In internal mode, hv_en_o never rises. AF follows the last clear byte after TICK_CYC*WAIT_MS idle cycles. Sleep sends AE, 8D, 10. Wake sends 8D, 14, waits TICK_CYC*WAIT_MS cycles, then sends AF.
- R10: busy_o is high from an accepted start until AF is accepted, and during every sleep, wake and power-down sequence. Any request while busy_o is high is ignored. Requests that do not apply in the current idle state (start while on or asleep, sleep while asleep) are also ignored.
- R11: While wr_valid_o is high and wr_ready_i is low, wr_valid_o, wr_byte_o and wr_is_data_o hold steady into the next cycle.
- R12: When sleep_i and off_i arrive together in the on state, power-down is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_supply_i | input | 1 | 1 = external panel supply, 0 = internal charge pump; sampled at start |
| start_i | input | 1 | Power-up request |
| sleep_i | input | 1 | Sleep request |
| wake_i | input | 1 | Wake request |
| off_i | input | 1 | Power-down request |
| wr_byte_o | output | 8 | Byte to write |
| wr_is_data_o | output | 1 | 1 = display data, 0 = command |
| wr_valid_o | output | 1 | Byte offered |
| wr_ready_i | input | 1 | Writer accepts the byte this cycle |
| logic_pwr_o | output | 1 | Module logic power enable |
| panel_rst_n_o | output | 1 | Module reset, active low |
| hv_en_o | output | 1 | External panel supply enable |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The bound checker watches the invariants that hold on every cycle. Logic power never drops while the panel supply is on, and reset is low whenever logic power is off. Bytes appear only outside reset, and an offered byte stays stable under back-pressure. The internal-pump mode never raises the supply enable, and nothing is offered while the block is idle.

The ordering and content of whole sequences can only be shown by the bench scenarios. These cover the reset pulse lengths, the exact byte streams for both supply modes, the clear pass layout, the stabilization waits before display on and before logic power-off, the sampling of the mode, requests that are ignored, and the priority of power-down over sleep. The bench compares each of these against a queue-based model under a stalling writer.

// File: rtl/dpy_power_seq.sv
module dpy_power_seq #(
  parameter int RST_CYC  = 1000,
  parameter int POST_CYC = 1000,
  parameter int TICK_CYC = 250000,
  parameter int WAIT_MS  = 100,
  parameter int COLS     = 128,
  parameter int PAGES    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_supply_i,
  input  logic       start_i,
  input  logic       sleep_i,
  input  logic       wake_i,
  input  logic       off_i,
  output logic [7:0] wr_byte_o,
  output logic       wr_is_data_o,
  output logic       wr_valid_o,
  input  logic       wr_ready_i,
  output logic       logic_pwr_o,
  output logic       panel_rst_n_o,
  output logic       hv_en_o,
  output logic       busy_o
);
  localparam int DMAX     = (RST_CYC > POST_CYC) ? RST_CYC : POST_CYC;
  localparam int CW       = $clog2(DMAX + 1);
  localparam int TW       = $clog2(TICK_CYC + 1);
  localparam int MW       = $clog2(WAIT_MS + 1);
  localparam int PW       = $clog2(PAGES + 1);
  localparam int CLW      = $clog2(COLS + 3);
  localparam int INIT_LEN = 24;

  typedef enum logic [3:0] {
    S_OFF, S_RH1, S_RL, S_RH2, S_INIT, S_CLR, S_WT_ON, S_SEND_ON,
    S_ON, S_SLP, S_SLEEP, S_WAKE, S_DN, S_WT_DN
  } st_t;

  st_t            st;
  logic           ext_q, hv_q;
  logic [CW-1:0]  dcnt;
  logic [4:0]     idx;
  logic [PW-1:0]  page;
  logic [CLW-1:0] col;
  logic [TW-1:0]  tick;
  logic [MW-1:0]  ms;

  function automatic logic [7:0] init_byte(input logic [4:0] i, input logic ext);
    case (i)
      5'd0:  return 8'hAE;  5'd1:  return 8'h00;  5'd2:  return 8'h10;
      5'd3:  return 8'h40;  5'd4:  return 8'hB0;  5'd5:  return 8'h81;
      5'd6:  return 8'hCF;  5'd7:  return 8'hA1;  5'd8:  return 8'hA6;
      5'd9:  return 8'hA8;  5'd10: return 8'h3F;  5'd11: return 8'hC8;
      5'd12: return 8'hD3;  5'd13: return 8'h00;  5'd14: return 8'hD5;
      5'd15: return 8'h80;  5'd16: return 8'hD9;  5'd17: return 8'hF1;
      5'd18: return 8'hDA;  5'd19: return 8'h12;  5'd20: return 8'hDB;
      5'd21: return 8'h30;  5'd22: return 8'h8D;
      default: return ext ? 8'h10 : 8'h14;
    endcase
  endfunction

  wire hs        = wr_valid_o & wr_ready_i;
  wire waiting   = (st == S_WT_ON) || (st == S_WT_DN);
  wire wait_done = (tick == TW'(TICK_CYC - 1)) && (ms == MW'(WAIT_MS - 1));
  wire off_last  = ext_q ? (idx == 5'd0) : (idx == 5'd2);
  wire clr_last  = (col == CLW'(COLS + 2)) && (page == PW'(PAGES - 1));

  assign logic_pwr_o   = (st != S_OFF);
  assign panel_rst_n_o = (st != S_OFF) && (st != S_RL);
  assign hv_en_o       = hv_q;
  assign busy_o        = !((st == S_OFF) || (st == S_ON) || (st == S_SLEEP));
  assign wr_valid_o    = (st == S_INIT) || (st == S_CLR) || (st == S_SEND_ON) ||
                         (st == S_SLP) || (st == S_DN) || (st == S_WAKE);

  always_comb begin
    wr_byte_o    = 8'h00;
    wr_is_data_o = 1'b0;
    case (st)
      S_INIT:    wr_byte_o = init_byte(idx, ext_q);
      S_CLR: begin
        if (col == CLW'(0))      wr_byte_o = 8'hB0 + 8'(page);
        else if (col == CLW'(2)) wr_byte_o = 8'h10;
        wr_is_data_o = (col >= CLW'(3));
      end
      S_SEND_ON: wr_byte_o = 8'hAF;
      S_SLP, S_DN: wr_byte_o = (idx == 5'd0) ? 8'hAE : (idx == 5'd1) ? 8'h8D : 8'h10;
      S_WAKE:    wr_byte_o = (idx == 5'd0) ? 8'h8D : 8'h14;
      default:   wr_byte_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
      ms   <= '0;
    end else if (!waiting || wait_done) begin
      tick <= '0;
      ms   <= '0;
    end else if (tick == TW'(TICK_CYC - 1)) begin
      tick <= '0;
      ms   <= ms + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      ext_q <= 1'b1;
      hv_q  <= 1'b0;
      dcnt  <= '0;
      idx   <= '0;
      page  <= '0;
      col   <= '0;
    end else begin
      case (st)
        S_OFF: if (start_i) begin
          ext_q <= ext_supply_i;
          dcnt  <= '0;
          st    <= S_RH1;
        end
        S_RH1: if (dcnt == CW'(RST_CYC - 1)) begin
          dcnt <= '0;
          st   <= S_RL;
        end else dcnt <= dcnt + 1'b1;
        S_RL: if (dcnt == CW'(RST_CYC - 1)) begin
          dcnt <= '0;
          st   <= S_RH2;
        end else dcnt <= dcnt + 1'b1;
        S_RH2: if (dcnt == CW'(POST_CYC - 1)) begin
          dcnt <= '0;
          idx  <= '0;
          st   <= S_INIT;
        end else dcnt <= dcnt + 1'b1;
        S_INIT: if (hs) begin
          if (idx == 5'(INIT_LEN - 1)) begin
            idx  <= '0;
            page <= '0;
            col  <= '0;
            st   <= S_CLR;
          end else idx <= idx + 1'b1;
        end
        S_CLR: if (hs) begin
          if (clr_last) begin
            hv_q <= ext_q;
            st   <= S_WT_ON;
          end else if (col == CLW'(COLS + 2)) begin
            col  <= '0;
            page <= page + 1'b1;
          end else col <= col + 1'b1;
        end
        S_WT_ON:   if (wait_done) st <= S_SEND_ON;
        S_SEND_ON: if (hs) st <= S_ON;
        S_ON: if (off_i) begin
          idx <= '0;
          st  <= S_DN;
        end else if (sleep_i) begin
          idx <= '0;
          st  <= S_SLP;
        end
        S_SLP: if (hs) begin
          if (off_last) begin
            hv_q <= 1'b0;
            st   <= S_SLEEP;
          end else idx <= idx + 1'b1;
        end
        S_SLEEP: if (wake_i) begin
          idx <= '0;
          if (ext_q) begin
            hv_q <= 1'b1;
            st   <= S_WT_ON;
          end else st <= S_WAKE;
        end
        S_WAKE: if (hs) begin
          if (idx == 5'd1) st <= S_WT_ON;
          else idx <= idx + 1'b1;
        end
        S_DN: if (hs) begin
          if (off_last) begin
            hv_q <= 1'b0;
            st   <= S_WT_DN;
          end else idx <= idx + 1'b1;
        end
        S_WT_DN: if (wait_done) st <= S_OFF;
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/dpy_power_seq_chk.sv
module dpy_power_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       logic_pwr,
  input logic       panel_rst_n,
  input logic       hv_en,
  input logic       busy,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_byte,
  input logic       wr_is_data,
  input logic       ext_mode
);
  assert_rst_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !logic_pwr |-> !panel_rst_n);

  assert_bytes_out_of_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (panel_rst_n && logic_pwr));

  assert_hv_needs_logic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |-> logic_pwr);

  assert_logic_drop_after_hv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_pwr) |-> (!hv_en && !$past(hv_en)));

  assert_pump_mode_no_hv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> !hv_en);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

  assert_hold_under_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_byte) && $stable(wr_is_data)));
endmodule

bind dpy_power_seq dpy_power_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .logic_pwr(logic_pwr_o), .panel_rst_n(panel_rst_n_o),
  .hv_en(hv_en_o), .busy(busy_o), .wr_valid(wr_valid_o), .wr_ready(wr_ready_i),
  .wr_byte(wr_byte_o), .wr_is_data(wr_is_data_o), .ext_mode(ext_q)
);

// File: tb/dpy_power_seq_test.sv
`timescale 1ns/1ps
module dpy_power_seq_test;
  localparam int RC = 3, PC = 4, TC = 4, WM = 5, NW = TC * WM;
  localparam int COLS = 128, PAGES = 8;

  logic clk = 0, rst_n = 0;
  logic ext_supply_i = 1, start_i = 0, sleep_i = 0, wake_i = 0, off_i = 0;
  logic wr_ready_i = 1;
  logic [7:0] wr_byte_o;
  logic wr_is_data_o, wr_valid_o, logic_pwr_o, panel_rst_n_o, hv_en_o, busy_o;

  always #2 clk = ~clk;

  dpy_power_seq #(.RST_CYC(RC), .POST_CYC(PC), .TICK_CYC(TC), .WAIT_MS(WM),
                  .COLS(COLS), .PAGES(PAGES)) uut (
    .clk(clk), .rst_n(rst_n), .ext_supply_i(ext_supply_i), .start_i(start_i),
    .sleep_i(sleep_i), .wake_i(wake_i), .off_i(off_i), .wr_byte_o(wr_byte_o),
    .wr_is_data_o(wr_is_data_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .logic_pwr_o(logic_pwr_o), .panel_rst_n_o(panel_rst_n_o), .hv_en_o(hv_en_o),
    .busy_o(busy_o));

  int checks = 0, failures = 0, cyc = 0;
  bit mon_on = 0, pump_run = 0, done = 0;
  logic [7:0] eb_q[$];
  bit         ed_q[$];
  string      et_q[$];
  bit pv = 0, pr = 1, pd = 0;
  logic [7:0] pb = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit d, input string t);
    eb_q.push_back(b); ed_q.push_back(d); et_q.push_back(t);
  endtask

  task automatic push_init(input bit ext);
    logic [7:0] lst [23] = '{8'hAE, 8'h00, 8'h10, 8'h40, 8'hB0, 8'h81, 8'hCF, 8'hA1,
                             8'hA6, 8'hA8, 8'h3F, 8'hC8, 8'hD3, 8'h00, 8'hD5, 8'h80,
                             8'hD9, 8'hF1, 8'hDA, 8'h12, 8'hDB, 8'h30, 8'h8D};
    for (int i = 0; i < 23; i++) push(lst[i], 1'b0, "R3");
    push(ext ? 8'h10 : 8'h14, 1'b0, "R4");
  endtask

  task automatic push_clear();
    for (int p = 0; p < PAGES; p++) begin
      push(8'hB0 + 8'(p), 1'b0, "R5");
      push(8'h00, 1'b0, "R5");
      push(8'h10, 1'b0, "R5");
      for (int c = 0; c < COLS; c++) push(8'h00, 1'b1, "R5");
    end
  endtask

  task automatic pulse(input bit s, input bit sl, input bit w, input bit o);
    @(negedge clk);
    start_i = s; sleep_i = sl; wake_i = w; off_i = o;
    @(negedge clk);
    start_i = 0; sleep_i = 0; wake_i = 0; off_i = 0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  // reference model: expected byte queue, per-cycle invariants, stall hold
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (pv && !pr)
        chk(wr_valid_o && wr_byte_o == pb && wr_is_data_o == pd, "R11 hold",
            {wr_valid_o, wr_is_data_o, wr_byte_o}, {1'b1, pd, pb});
      chk(!(hv_en_o && !logic_pwr_o), "R8 hv without logic", hv_en_o, 0);
      chk(!(wr_valid_o && (!panel_rst_n_o || !logic_pwr_o)), "R2 byte in reset",
          panel_rst_n_o, 1);
      if (pump_run) chk(!hv_en_o, "R9 hv in pump mode", hv_en_o, 0);
      wr_ready_i = !((cyc % 5) == 2 || (cyc % 7) == 0);
      if (wr_valid_o && wr_ready_i) begin
        if (eb_q.size() == 0) chk(0, "R3 unexpected byte", wr_byte_o, 0);
        else begin
          chk(wr_byte_o == eb_q[0] && wr_is_data_o == ed_q[0], et_q[0],
              {wr_is_data_o, wr_byte_o}, {ed_q[0], eb_q[0]});
          void'(eb_q.pop_front()); void'(ed_q.pop_front()); void'(et_q.pop_front());
        end
      end
      pv = wr_valid_o; pr = wr_ready_i; pb = wr_byte_o; pd = wr_is_data_o;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R10 watchdog expired busy=%0d expected=0", busy_o);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk(!logic_pwr_o && !panel_rst_n_o && !hv_en_o && !busy_o && !wr_valid_o, "R1 in reset",
        {logic_pwr_o, panel_rst_n_o, hv_en_o, busy_o, wr_valid_o}, 0);
    rst_n = 1; mon_on = 1;
    repeat (3) @(negedge clk);
    chk(!logic_pwr_o && !panel_rst_n_o && !hv_en_o && !busy_o && !wr_valid_o, "R1 after reset",
        {logic_pwr_o, panel_rst_n_o, hv_en_o, busy_o, wr_valid_o}, 0);

    // external supply power-up
    push_init(1'b1); push_clear(); push(8'hAF, 1'b0, "R6");
    ext_supply_i = 1;
    pulse(1, 0, 0, 0);
    chk(logic_pwr_o && busy_o, "R2 R10 logic up busy", {logic_pwr_o, busy_o}, 3);
    c = 0; while (panel_rst_n_o) begin c++; @(negedge clk); end
    chk(c == RC, "R2 first high", c, RC);
    c = 0; while (!panel_rst_n_o) begin c++; @(negedge clk); end
    chk(c == RC, "R2 low pulse", c, RC);
    c = 0; while (!wr_valid_o) begin c++; @(negedge clk); end
    chk(c == PC, "R2 post wait", c, PC);
    ext_supply_i = 0;
    pulse(0, 1, 0, 0); pulse(0, 0, 0, 1); pulse(1, 0, 1, 0);
    while (wr_valid_o) @(negedge clk);
    chk(hv_en_o, "R6 supply after clear", hv_en_o, 1);
    chk(eb_q.size() == 1, "R6 clear done first", eb_q.size(), 1);
    c = 0; while (!wr_valid_o) begin chk(busy_o, "R10 busy in wait", busy_o, 1); c++; @(negedge clk); end
    chk(c == NW, "R6 wait before on", c, NW);
    wait_idle();
    chk(eb_q.size() == 0 && hv_en_o, "R10 idle after on", eb_q.size(), 0);

    // external sleep and wake
    ext_supply_i = 1;
    push(8'hAE, 1'b0, "R7");
    pulse(0, 1, 0, 0);
    wait_idle();
    chk(!hv_en_o && logic_pwr_o && eb_q.size() == 0, "R7 asleep", {hv_en_o, logic_pwr_o}, 1);
    pulse(0, 1, 0, 0); pulse(1, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(!busy_o && !wr_valid_o && !hv_en_o, "R10 ignored in sleep", {busy_o, wr_valid_o}, 0);
    push(8'hAF, 1'b0, "R7");
    pulse(0, 0, 1, 0);
    chk(hv_en_o, "R7 supply on wake", hv_en_o, 1);
    c = 0; while (!wr_valid_o) begin c++; @(negedge clk); end
    chk(c == NW, "R7 wake wait", c, NW);
    wait_idle();

    // external power-down
    push(8'hAE, 1'b0, "R8");
    pulse(0, 0, 0, 1);
    while (hv_en_o) @(negedge clk);
    c = 0; while (logic_pwr_o) begin c++; @(negedge clk); end
    chk(c == NW, "R8 logic hold", c, NW);
    chk(!panel_rst_n_o && !busy_o && eb_q.size() == 0, "R8 off state", {panel_rst_n_o, busy_o}, 0);

    // internal charge pump power-up
    ext_supply_i = 0; pump_run = 1;
    push_init(1'b0); push_clear(); push(8'hAF, 1'b0, "R9");
    pulse(1, 0, 0, 0);
    ext_supply_i = 1;
    while (!wr_valid_o) @(negedge clk);
    while (wr_valid_o) @(negedge clk);
    c = 0; while (!wr_valid_o) begin c++; @(negedge clk); end
    chk(c == NW, "R9 wait before on", c, NW);
    wait_idle();
    chk(eb_q.size() == 0, "R4 R9 stream done", eb_q.size(), 0);

    push(8'hAE, 1'b0, "R9"); push(8'h8D, 1'b0, "R9"); push(8'h10, 1'b0, "R9");
    pulse(0, 1, 0, 0);
    wait_idle();
    chk(logic_pwr_o && eb_q.size() == 0, "R9 asleep", eb_q.size(), 0);
    push(8'h8D, 1'b0, "R9"); push(8'h14, 1'b0, "R9"); push(8'hAF, 1'b0, "R9");
    pulse(0, 0, 1, 0);
    while (wr_valid_o) @(negedge clk);
    c = 0; while (!wr_valid_o) begin c++; @(negedge clk); end
    chk(c == NW, "R9 wake wait", c, NW);
    wait_idle();

    // sleep and off together: power-down wins
    push(8'hAE, 1'b0, "R12"); push(8'h8D, 1'b0, "R12"); push(8'h10, 1'b0, "R12");
    pulse(0, 1, 0, 1);
    while (wr_valid_o) @(negedge clk);
    c = 0; while (logic_pwr_o) begin c++; @(negedge clk); end
    chk(c == NW, "R12 R8 power-down taken", c, NW);
    chk(!panel_rst_n_o && !busy_o && eb_q.size() == 0, "R12 off state", eb_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule